// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block is a small, fully associative store of finished address translations for a core that runs guests under hardware-assisted virtualization. It keeps three kinds of mapping side by side: linear (guest-virtual page to frame, used while nested translation is off), guest-physical (guest-physical page to host frame, used while nested translation is on) and combined (guest-virtual page to host frame through both levels). Each kind carries only the context tags that give it meaning. Linear entries hold the virtual-processor ID and the process-context ID. Guest-physical entries hold the nested-table root. Combined entries hold all three.

A page walker offers each result it produces on the fill port. With the fill it gives the status of the guest table entry and the nested table entry that the result came from. The cache applies the mode rules and stores the mapping only when the current mode and that status allow it. The lookup port matches one mapping kind against the live context and returns hit, frame and permissions in the same cycle. A flush input empties the whole cache.

Top module: `xlat_tag_cache`

## Requirements
- R1: After reset no lookup of any kind hits.
- R2: A lookup hits only when a valid entry has the requested kind (2'b00 linear, 2'b01 guest-physical, 2'b10 combined) and page number, and every tag of that kind equals its current value. On a hit, frame and permissions appear in the same cycle.
- R3: While `nest_en` is 0, only linear fills are stored. Each is tagged with the current `cur_vpid` and the effective PCID, so a lookup under a different VPID or PCID misses.
- R4: While `nest_en` is 1, linear fills are dropped. Guest-physical entries are tagged with the root, which is `nest_ptr[51:12]` at fill time. Bits outside 51:12 never affect a match.
- R5: A linear or combined fill is dropped when `gst_present` is 0 or `gst_rsvd` is 1.
- R6: A guest-physical or combined fill is dropped when `nest_rwx` is 3'b000 or `nest_bad` is 1.
- R7: A combined fill is dropped while `pg_en` is 0.
- R8: While `pcid_en` is 0, the effective PCID is 12'h000, whatever `cur_pcid` holds. This applies to both fills and lookups.
- R9: Combined entries that differ only in root coexist, and so do combined entries that differ only in VPID.
- R10: A new key goes into the lowest invalid slot. When no slot is invalid, a round-robin pointer picks the victim, starting at slot 0 after reset and advancing by one after each eviction.
- R11: A stored fill whose key (kind, page and that kind's tags) matches an existing entry overwrites that entry. It allocates no second copy.
- R12: Asserting `flush` invalidates every entry at the next clock edge.
- R13: A dropped fill leaves every entry unchanged and evicts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nest_en | input | 1 | Nested translation enabled |
| pg_en | input | 1 | Guest paging enabled |
| pcid_en | input | 1 | Process-context IDs in use |
| cur_vpid | input | 16 | Current virtual-processor ID |
| cur_pcid | input | 12 | Current process-context ID |
| nest_ptr | input | 64 | Nested-table pointer; root is bits 51:12 |
| flush | input | 1 | Invalidate all entries |
| fill_vld | input | 1 | Fill request |
| fill_kind | input | 2 | Kind of the offered mapping |
| fill_page | input | 36 | Page number of the offered mapping |
| fill_frame | input | 40 | Frame of the offered mapping |
| fill_perm | input | 3 | Permission bits of the offered mapping |
| gst_present | input | 1 | Guest table entry bit 0 |
| gst_rsvd | input | 1 | Guest table entry sets a reserved bit |
| nest_rwx | input | 3 | Nested table entry bits 2:0 |
| nest_bad | input | 1 | Nested table entry is misconfigured |
| lk_kind | input | 2 | Kind to look up |
| lk_page | input | 36 | Page number to look up |
| lk_hit | output | 1 | Lookup hit |
| lk_frame | output | 40 | Frame on hit, zero otherwise |
| lk_perm | output | 3 | Permissions on hit, zero otherwise |

## Verification
A lookup is purely combinational. Its result is due in the same cycle as the lookup inputs and the mode inputs, so the bench changes those inputs on the falling edge and samples one nanosecond later. A fill or flush takes effect at the next rising edge. The bench therefore raises it on a falling edge, drops it on the next falling edge, and only then looks up, so every check reads state one register stage after the request. Drop and eviction cases are checked by looking up every key that could have been disturbed.

// File: rtl/xlat_tag_cache.sv
module xlat_tag_cache #(
  parameter int N      = 8,
  parameter int PN_W   = 36,
  parameter int FR_W   = 40,
  parameter int PERM_W = 3,
  parameter int VPID_W = 16,
  parameter int PCID_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nest_en,
  input  logic              pg_en,
  input  logic              pcid_en,
  input  logic [VPID_W-1:0] cur_vpid,
  input  logic [PCID_W-1:0] cur_pcid,
  input  logic [63:0]       nest_ptr,
  input  logic              flush,
  input  logic              fill_vld,
  input  logic [1:0]        fill_kind,
  input  logic [PN_W-1:0]   fill_page,
  input  logic [FR_W-1:0]   fill_frame,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              gst_present,
  input  logic              gst_rsvd,
  input  logic [2:0]        nest_rwx,
  input  logic              nest_bad,
  input  logic [1:0]        lk_kind,
  input  logic [PN_W-1:0]   lk_page,
  output logic              lk_hit,
  output logic [FR_W-1:0]   lk_frame,
  output logic [PERM_W-1:0] lk_perm
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [1:0] K_LIN = 2'b00, K_GPA = 2'b01, K_CMB = 2'b10;

  logic [N-1:0]      valid_q;
  logic [1:0]        kind_q  [N];
  logic [PN_W-1:0]   page_q  [N];
  logic [FR_W-1:0]   frame_q [N];
  logic [PERM_W-1:0] perm_q  [N];
  logic [VPID_W-1:0] vpid_q  [N];
  logic [PCID_W-1:0] pcid_q  [N];
  logic [39:0]       root_q  [N];
  logic [IW-1:0]     rr_q;

  wire [PCID_W-1:0] eff_pcid = pcid_en ? cur_pcid : '0;
  wire [39:0]       cur_root = nest_ptr[51:12];
  wire gst_ok  = gst_present && !gst_rsvd;
  wire nest_ok = (nest_rwx != 3'b000) && !nest_bad;

  logic allow;
  always_comb begin
    case (fill_kind)
      K_LIN:   allow = !nest_en && gst_ok;
      K_GPA:   allow = nest_en && nest_ok;
      K_CMB:   allow = nest_en && pg_en && gst_ok && nest_ok;
      default: allow = 1'b0;
    endcase
  end
  wire do_fill = fill_vld && allow && !flush;

  logic [N-1:0] hit_vec, key_vec;
  for (genvar i = 0; i < N; i++) begin : g_cmp
    wire vp = vpid_q[i] == cur_vpid;
    wire pc = pcid_q[i] == eff_pcid;
    wire rt = root_q[i] == cur_root;
    wire tg = (kind_q[i] == K_LIN) ? (vp && pc) :
              (kind_q[i] == K_GPA) ? rt : (vp && pc && rt);
    assign hit_vec[i] = valid_q[i] && kind_q[i] == lk_kind   && page_q[i] == lk_page   && tg;
    assign key_vec[i] = valid_q[i] && kind_q[i] == fill_kind && page_q[i] == fill_page && tg;
  end

  always_comb begin
    lk_frame = '0;
    lk_perm  = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) begin
        lk_frame = lk_frame | frame_q[i];
        lk_perm  = lk_perm  | perm_q[i];
      end
  end
  assign lk_hit = |hit_vec;

  logic [IW-1:0] slot;
  logic          use_rr;
  always_comb begin
    slot   = rr_q;
    use_rr = 1'b1;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        slot   = IW'(i);
        use_rr = 1'b0;
      end
    for (int i = 0; i < N; i++)
      if (key_vec[i]) begin
        slot   = IW'(i);
        use_rr = 1'b0;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (do_fill) begin
      valid_q[slot] <= 1'b1;
      if (use_rr) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      kind_q[slot]  <= fill_kind;
      page_q[slot]  <= fill_page;
      frame_q[slot] <= fill_frame;
      perm_q[slot]  <= fill_perm;
      vpid_q[slot]  <= cur_vpid;
      pcid_q[slot]  <= eff_pcid;
      root_q[slot]  <= cur_root;
    end
  end
endmodule

module xlat_tag_cache_chk #(parameter int N = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         fill_vld,
  input logic [1:0]   fill_kind,
  input logic         nest_en,
  input logic         pg_en,
  input logic         gst_present,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] hit_vec,
  input logic         lk_hit
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0)); // R12
  AST_NO_LINEAR_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && !flush && nest_en && fill_kind == 2'b00) |=> $stable(valid_q)); // R4
  AST_NO_CMB_UNPAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && !flush && !pg_en && fill_kind == 2'b10) |=> $stable(valid_q)); // R7
  AST_NO_GST_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && !flush && !gst_present && fill_kind != 2'b01) |=> $stable(valid_q)); // R5
  AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R11
  AST_EMPTY_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q == '0) |-> !lk_hit); // R1
endmodule

bind xlat_tag_cache xlat_tag_cache_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fill_vld(fill_vld),
  .fill_kind(fill_kind), .nest_en(nest_en), .pg_en(pg_en),
  .gst_present(gst_present), .valid_q(valid_q), .hit_vec(hit_vec),
  .lk_hit(lk_hit));

// File: tb/xlat_tag_cache_tb.sv
module xlat_tag_cache_tb_top;
  logic clk = 0, rst_n = 0;
  logic nest_en = 0, pg_en = 0, pcid_en = 0;
  logic [15:0] cur_vpid = 0;
  logic [11:0] cur_pcid = 0;
  logic [63:0] nest_ptr = 0;
  logic flush = 0, fill_vld = 0;
  logic [1:0] fill_kind = 0, lk_kind = 0;
  logic [35:0] fill_page = 0, lk_page = 0;
  logic [39:0] fill_frame = 0, lk_frame;
  logic [2:0] fill_perm = 0, lk_perm, nest_rwx = 3'b111;
  logic gst_present = 1, gst_rsvd = 0, nest_bad = 0, lk_hit;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  xlat_tag_cache dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(logic [1:0] k, logic [35:0] pg, logic [39:0] fr, logic [2:0] pm);
    @(negedge clk);
    fill_kind = k; fill_page = pg; fill_frame = fr; fill_perm = pm; fill_vld = 1;
    @(negedge clk);
    fill_vld = 0;
  endtask

  task automatic look(logic [1:0] k, logic [35:0] pg);
    lk_kind = k; lk_page = pg;
    #1;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    look(2'b00, 36'h0); check("R1 hit lin", lk_hit, 0);
    look(2'b01, 36'h0); check("R1 hit gpa", lk_hit, 0);
  endtask

  task automatic t_linear();
    nest_en = 0; pcid_en = 1; cur_vpid = 5; cur_pcid = 12'h012;
    fill(2'b00, 36'h100, 40'hAAA, 3'd5);
    look(2'b00, 36'h100);
    check("R2 hit", lk_hit, 1); check("R2 frame", lk_frame, 40'hAAA); check("R2 perm", lk_perm, 5);
    look(2'b00, 36'h101); check("R2 other page", lk_hit, 0);
    look(2'b01, 36'h100); check("R2 other kind", lk_hit, 0);
    cur_vpid = 6; look(2'b00, 36'h100); check("R3 vpid tag", lk_hit, 0);
    cur_vpid = 5; cur_pcid = 12'h013; look(2'b00, 36'h100); check("R3 pcid tag", lk_hit, 0);
    cur_pcid = 12'h012;
    fill(2'b01, 36'h110, 40'hBBB, 3'd7);
    look(2'b01, 36'h110); check("R3 gpa without nest", lk_hit, 0);
  endtask

  task automatic t_pcid_off();
    do_flush();
    pcid_en = 0; cur_pcid = 12'h033;
    fill(2'b00, 36'h200, 40'hC00, 3'd1);
    cur_pcid = 12'h044; look(2'b00, 36'h200); check("R8 pcid ignored", lk_hit, 1);
    pcid_en = 1; cur_pcid = 12'h000; look(2'b00, 36'h200); check("R8 tagged zero", lk_hit, 1);
    cur_pcid = 12'h033; look(2'b00, 36'h200); check("R8 not tagged 033", lk_hit, 0);
  endtask

  task automatic t_nested();
    do_flush();
    nest_en = 1; pg_en = 1; nest_ptr = 64'h0000_0123_4567_805E;
    fill(2'b00, 36'h300, 40'hD00, 3'd3);
    look(2'b00, 36'h300); check("R4 linear dropped", lk_hit, 0);
    fill(2'b01, 36'h300, 40'hD01, 3'd6);
    look(2'b01, 36'h300); check("R4 gpa stored", lk_frame, 40'hD01);
    nest_ptr = 64'hFFF0_0123_4567_801E; look(2'b01, 36'h300); check("R4 low/high bits ignored", lk_hit, 1);
    nest_ptr = 64'h0000_0123_4567_905E; look(2'b01, 36'h300); check("R4 root bit 12", lk_hit, 0);
    nest_ptr = 64'h0000_0123_4567_805E;
    nest_rwx = 3'b000; fill(2'b01, 36'h310, 40'hD02, 3'd1);
    look(2'b01, 36'h310); check("R6 rwx zero gpa", lk_hit, 0);
    fill(2'b10, 36'h311, 40'hD03, 3'd1);
    look(2'b10, 36'h311); check("R6 rwx zero cmb", lk_hit, 0);
    nest_rwx = 3'b100; nest_bad = 1; fill(2'b01, 36'h312, 40'hD04, 3'd1);
    look(2'b01, 36'h312); check("R6 misconfig", lk_hit, 0);
    nest_bad = 0; nest_rwx = 3'b111;
  endtask

  task automatic t_guest_bad();
    do_flush();
    nest_en = 0; gst_present = 0; fill(2'b00, 36'h400, 40'hE00, 3'd1);
    look(2'b00, 36'h400); check("R5 absent lin", lk_hit, 0);
    gst_present = 1; gst_rsvd = 1; fill(2'b00, 36'h401, 40'hE01, 3'd1);
    look(2'b00, 36'h401); check("R5 rsvd lin", lk_hit, 0);
    gst_rsvd = 0; nest_en = 1; pg_en = 1; gst_present = 0; fill(2'b10, 36'h402, 40'hE02, 3'd1);
    look(2'b10, 36'h402); check("R5 absent cmb", lk_hit, 0);
    gst_present = 1;
  endtask

  task automatic t_combined();
    do_flush();
    nest_en = 1; pg_en = 0; cur_vpid = 7; pcid_en = 1; cur_pcid = 12'h001;
    nest_ptr = 64'h0000_000A_0000_0000;
    fill(2'b10, 36'h500, 40'hF00, 3'd2);
    look(2'b10, 36'h500); check("R7 unpaged cmb", lk_hit, 0);
    pg_en = 1; fill(2'b10, 36'h500, 40'hF01, 3'd2);
    nest_ptr = 64'h0000_000B_0000_0000; fill(2'b10, 36'h500, 40'hF02, 3'd4);
    look(2'b10, 36'h500); check("R9 root B", lk_frame, 40'hF02);
    nest_ptr = 64'h0000_000A_0000_0000;
    look(2'b10, 36'h500); check("R9 root A", lk_frame, 40'hF01);
    cur_vpid = 8; fill(2'b10, 36'h500, 40'hF03, 3'd1);
    look(2'b10, 36'h500); check("R9 vpid 8", lk_frame, 40'hF03);
    cur_vpid = 7; look(2'b10, 36'h500); check("R9 vpid 7", lk_frame, 40'hF01);
  endtask

  task automatic t_replace();
    do_flush();
    nest_en = 0; cur_vpid = 1; pcid_en = 0;
    for (int i = 0; i < 8; i++) fill(2'b00, 36'(i), 40'(16 + i), 3'd1);
    gst_present = 0; fill(2'b00, 36'h8, 40'h99, 3'd1); gst_present = 1;
    for (int i = 0; i < 8; i++) begin
      look(2'b00, 36'(i)); check("R13 kept after drop", lk_frame, 40'(16 + i));
    end
    look(2'b00, 36'h8); check("R13 dropped absent", lk_hit, 0);
    fill(2'b00, 36'h3, 40'h777, 3'd6);
    look(2'b00, 36'h3); check("R11 overwrite frame", lk_frame, 40'h777);
    for (int i = 0; i < 8; i++) begin
      look(2'b00, 36'(i)); check("R11 no eviction", lk_hit, 1);
    end
    fill(2'b00, 36'h8, 40'h88, 3'd1);
    look(2'b00, 36'h0); check("R10 victim slot0", lk_hit, 0);
    look(2'b00, 36'h8); check("R10 new stored", lk_frame, 40'h88);
    fill(2'b00, 36'h9, 40'h89, 3'd1);
    look(2'b00, 36'h1); check("R10 victim slot1", lk_hit, 0);
    look(2'b00, 36'h2); check("R10 slot2 kept", lk_hit, 1);
  endtask

  task automatic t_flush();
    do_flush();
    for (int i = 2; i < 10; i++) begin
      look(2'b00, 36'(i)); check("R12 flushed", lk_hit, 0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_pcid_off();
    t_nested();
    t_guest_bad();
    t_combined();
    t_replace();
    t_flush();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule